// File: doc/BRIEF.md
# Word-serial modular adder/subtractor

This block forms either (a + b) mod q or (a − b) mod q for multi-word operands, one word per clock, starting from the least significant word. Its default is 256-bit operands held as eight 32-bit words, with q set to the P-256 prime. The caller pulses a start strobe and chooses the operation. The block then asks for operand words by index, and the caller supplies the matching words of a and b in the same cycle.

Two carry/borrow chains run side by side. For addition, the first chain forms a + b and the second subtracts q from that sum. For subtraction, the first chain forms a − b and the second adds q back. Both candidate words are stored. Once the last word has been processed, the final chain flags decide which candidate is correct, with no magnitude comparison. The chosen words then go out on a write port, lowest index first, and a done pulse follows the last one. Both inputs are assumed to be already reduced below q.

Top module: `modarith_addsub`

## Requirements
- R1: With op_sub_i = 0 at start and a, b < q, the eight result words make up (a + b) mod q, with word 0 the least significant.
- R2: With op_sub_i = 1 at start and a, b < q, the result is (a − b) mod q, that is a − b when a ≥ b and a − b + q otherwise.
- R3: In an addition whose raw sum reaches 2^256 or more, so that the sum chain carries out and the q-subtraction chain borrows out, the result is a + b − q.
- R4: In cycle k after the start strobe is sampled (k = 1..8), rd_addr_o equals k − 1. The operand words of that index are taken from a_word_i and b_word_i in that cycle.
- R5: In cycles 9..16 after start, res_we_o is 1 and res_addr_o runs 0 through 7 in ascending order, one word per cycle. res_we_o is 0 in every other cycle.
- R6: done_o is a single-cycle pulse in cycle 17 after start. res_we_o is 0 in that cycle.
- R7: A start strobe that arrives while an operation is in progress is ignored. The running operation completes unchanged, and no second operation follows it.
- R8: While rst_ni is low, and after it is released, res_we_o and done_o are 0. A reset during an operation aborts it, so no further writes and no done pulse appear.
- R9: The operation is taken from op_sub_i only in the cycle start is sampled. Changing op_sub_i later does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled only while idle |
| op_sub_i | input | 1 | 0 = modular add, 1 = modular subtract |
| rd_addr_o | output | 3 | Index of the operand word requested this cycle |
| a_word_i | input | 32 | Word rd_addr_o of operand a |
| b_word_i | input | 32 | Word rd_addr_o of operand b |
| res_word_o | output | 32 | Result word |
| res_addr_o | output | 3 | Index of res_word_o |
| res_we_o | output | 1 | Result word write enable |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after the selection boundaries.

- **a + b = q.** The result must be zero. A design that keeps the raw sum on equality returns q.
- **Both operands equal to q − 1.** The sum overflows 256 bits and the carry cancels the borrow. A design that picks the raw sum whenever a borrow appears returns a value above 2^256 truncated.
- **a = b, a = 0, and b = q − 1.** These exercise the subtraction borrow. A wrong choice there shows up as q, or as a negative value wrapped modulo 2^256.
- **Word-boundary carries.** Operands such as 2^32 catch a chain flag that is cleared or dropped between words.

Restarts during a run and late changes of the operation select check that the run is protected once it has begun.

// File: rtl/modarith_pkg.sv
package modarith_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_EMIT = 2'd2,
    ST_DONE = 2'd3
  } ma_state_e;
endpackage

// File: rtl/modarith_ctrl.sv
module modarith_ctrl
  import modarith_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             launch_o,
  output logic             calc_o,
  output logic             emit_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

  ma_state_e        state_q;
  logic [IDX_W-1:0] idx_q;

  assign launch_o = (state_q == ST_IDLE) && start_i;
  assign calc_o   = (state_q == ST_CALC);
  assign emit_o   = (state_q == ST_EMIT);
  assign done_o   = (state_q == ST_DONE);
  assign idx_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CALC;
          idx_q   <= '0;
        end
        ST_CALC: begin
          if (idx_q == LAST) begin
            state_q <= ST_EMIT;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_EMIT: begin
          if (idx_q == LAST) begin
            state_q <= ST_DONE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/modarith_step.sv
// One word of both chains: primary (a op b) and correction (primary -/+ q).
module modarith_step #(
  parameter int WORD_W = 32
) (
  input  logic              sub_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [WORD_W-1:0] q_i,
  input  logic              f1_i,
  input  logic              f2_i,
  output logic [WORD_W-1:0] raw_o,
  output logic [WORD_W-1:0] alt_o,
  output logic              f1_o,
  output logic              f2_o
);
  logic [WORD_W:0] prim, corr;

  always_comb begin
    if (sub_i) begin
      prim = {1'b0, a_i} - {1'b0, b_i} - {{WORD_W{1'b0}}, f1_i};
      corr = {1'b0, prim[WORD_W-1:0]} + {1'b0, q_i} + {{WORD_W{1'b0}}, f2_i};
    end else begin
      prim = {1'b0, a_i} + {1'b0, b_i} + {{WORD_W{1'b0}}, f1_i};
      corr = {1'b0, prim[WORD_W-1:0]} - {1'b0, q_i} - {{WORD_W{1'b0}}, f2_i};
    end
  end

  assign raw_o = prim[WORD_W-1:0];
  assign alt_o = corr[WORD_W-1:0];
  assign f1_o  = prim[WORD_W];
  assign f2_o  = corr[WORD_W];
endmodule

// File: rtl/modarith_wordbuf.sv
module modarith_wordbuf #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [NUM_WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/modarith_addsub.sv
module modarith_addsub #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  parameter logic [WORD_W*NUM_WORDS-1:0] MODULUS =
    256'hffffffff00000001000000000000000000000000ffffffffffffffffffffffff,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_sub_i,
  output logic [IDX_W-1:0]  rd_addr_o,
  input  logic [WORD_W-1:0] a_word_i,
  input  logic [WORD_W-1:0] b_word_i,
  output logic [WORD_W-1:0] res_word_o,
  output logic [IDX_W-1:0]  res_addr_o,
  output logic              res_we_o,
  output logic              done_o
);
  logic             launch, calc, emit, fin;
  logic [IDX_W-1:0] idx;
  logic             sub_q, f1_q, f2_q, f1_d, f2_d;
  logic [WORD_W-1:0] q_word, raw_w, alt_w, raw_rd, alt_rd;
  logic             use_alt;

  modarith_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .launch_o(launch), .calc_o(calc), .emit_o(emit), .done_o(fin), .idx_o(idx)
  );

  assign q_word = MODULUS[idx*WORD_W +: WORD_W];

  modarith_step #(.WORD_W(WORD_W)) u_step (
    .sub_i(sub_q), .a_i(a_word_i), .b_i(b_word_i), .q_i(q_word),
    .f1_i(f1_q), .f2_i(f2_q),
    .raw_o(raw_w), .alt_o(alt_w), .f1_o(f1_d), .f2_o(f2_d)
  );

  // op latched at launch; chain flags cleared for word 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= 1'b0;
      f1_q  <= 1'b0;
      f2_q  <= 1'b0;
    end else if (launch) begin
      sub_q <= op_sub_i;
      f1_q  <= 1'b0;
      f2_q  <= 1'b0;
    end else if (calc) begin
      f1_q <= f1_d;
      f2_q <= f2_d;
    end
  end

  modarith_wordbuf #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_raw_buf (
    .clk_i, .we_i(calc), .waddr_i(idx), .wdata_i(raw_w),
    .raddr_i(idx), .rdata_o(raw_rd)
  );

  modarith_wordbuf #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_alt_buf (
    .clk_i, .we_i(calc), .waddr_i(idx), .wdata_i(alt_w),
    .raddr_i(idx), .rdata_o(alt_rd)
  );

  // add: keep raw sum only if q-subtraction borrowed without sum carry
  // sub: add q back only if a-b borrowed
  assign use_alt = sub_q ? f1_q : !(f2_q && !f1_q);

  assign rd_addr_o  = idx;
  assign res_word_o = use_alt ? alt_rd : raw_rd;
  assign res_addr_o = idx;
  assign res_we_o   = emit;
  assign done_o     = fin;
endmodule

// File: rtl/modarith_addsub_chk.sv
module modarith_addsub_chk #(
  parameter int NUM_WORDS = 8,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             res_we_o,
  input logic [IDX_W-1:0] res_addr_o,
  input logic             done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !res_we_o);

  p_last_then_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_we_o && res_addr_o == LAST) |=> done_o);

  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_we_o && res_addr_o != LAST) |=>
      (res_we_o && res_addr_o == IDX_W'($past(res_addr_o) + 1'b1)));

  p_first_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_we_o) |-> (res_addr_o == '0));

  p_idle_after_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !res_we_o);
endmodule

bind modarith_addsub modarith_addsub_chk #(.NUM_WORDS(NUM_WORDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .res_we_o(res_we_o),
  .res_addr_o(res_addr_o), .done_o(done_o)
);

// File: tb/modarith_addsub_test.sv
module modarith_addsub_test;
  localparam int W = 32;
  localparam int N = 8;
  localparam logic [255:0] Q =
    256'hffffffff00000001000000000000000000000000ffffffffffffffffffffffff;
  localparam int NV = 11;
  localparam logic [255:0] PA = 256'h0123456789abcdef_0011223344556677_8899aabbccddeeff_0f1e2d3c4b5a6978;
  localparam logic [255:0] PB = 256'hfedcba9876543210_ffeeddccbbaa9988_7766554433221100_f0e1d2c3b4a59687;
  localparam logic [255:0] TA [NV] = '{256'd1, Q - 256'd1, Q - 256'd1, 256'd5, 256'd0,
    256'd0, Q >> 1, PA, PA, 256'h1_0000_0000, Q - 256'd1};
  localparam logic [255:0] TB [NV] = '{256'd2, 256'd1, Q - 256'd1, 256'd5, Q - 256'd1,
    256'd7, Q - 256'd1, PB, PB, Q - 256'd1, 256'd0};
  localparam bit TS [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op_sub = 1'b0;
  logic [2:0] rd_addr, res_addr;
  logic [W-1:0] res_word;
  logic res_we, done;
  logic [255:0] op_a = '0, op_b = '0;
  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  modarith_addsub uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_sub_i(op_sub),
    .rd_addr_o(rd_addr), .a_word_i(op_a[rd_addr*W +: W]), .b_word_i(op_b[rd_addr*W +: W]),
    .res_word_o(res_word), .res_addr_o(res_addr), .res_we_o(res_we), .done_o(done)
  );

  task automatic finish_up();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: act=%0d exp<100000 cycles", cycles);
      finish_up();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] ref_model(input logic [255:0] a, input logic [255:0] b, input bit sub);
    logic [256:0] s;
    if (!sub) begin
      s = {1'b0, a} + {1'b0, b};
      if (s >= {1'b0, Q}) s = s - {1'b0, Q};
      return s[255:0];
    end
    if (a >= b) return a - b;
    return a - b + Q;
  endfunction

  // glitch: pulse start and flip op mid-run (R7, R9)
  task automatic run(input logic [255:0] a, input logic [255:0] b, input bit sub,
                     input bit glitch, input string req);
    logic [255:0] got, exp;
    bit seq_ok, we_ok, done_ok;
    got = '0; seq_ok = 1; we_ok = 1; done_ok = 1;
    exp = ref_model(a, b, sub);
    op_a = a; op_b = b; op_sub = sub;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 1; k <= 2 * N + 1; k++) begin
      if (k <= N) begin
        if (rd_addr !== 3'(k - 1)) seq_ok = 0;
        if (res_we !== 1'b0) we_ok = 0;
      end else if (k <= 2 * N) begin
        if (res_we !== 1'b1 || res_addr !== 3'(k - N - 1)) we_ok = 0;
        got[res_addr*W +: W] = res_word;
      end
      if (k <= 2 * N && done !== 1'b0) done_ok = 0;
      if (k == 2 * N + 1 && (done !== 1'b1 || res_we !== 1'b0)) done_ok = 0;
      if (glitch && k == 4) begin start = 1'b1; op_sub = ~sub; end
      if (glitch && k == 5) start = 1'b0;
      if (k < 2 * N + 1) @(negedge clk);
    end
    chk(got === exp, req, got, exp);
    chk(seq_ok, "R4 operand word order", seq_ok, 1);
    chk(we_ok, "R5 write window and order", we_ok, 1);
    chk(done_ok, "R6 done timing", done_ok, 1);
    @(negedge clk);
    chk(done === 1'b0, "R6 done single pulse", done, 0);
    op_sub = 1'b0;
  endtask

  initial begin
    #1;
    chk(done === 1'b0 && res_we === 1'b0, "R8 outputs low in reset", {done, res_we}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done === 1'b0 && res_we === 1'b0, "R8 outputs low after reset", {done, res_we}, 0);

    // vector table: R1 add, R2 sub, R3 case index 2 (both flags set)
    for (int i = 0; i < NV; i++)
      run(TA[i], TB[i], TS[i], 1'b0, (i == 2) ? "R3 add overflow" : (TS[i] ? "R2 sub" : "R1 add"));

    // R7/R9: restart and op flip during run ignored
    run(PA, PB, 1'b0, 1'b1, "R9 add with op flip");
    begin
      bit quiet;
      quiet = 1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (res_we !== 1'b0 || done !== 1'b0) quiet = 0;
      end
      chk(quiet, "R7 no second run after ignored start", quiet, 1);
    end
    run(Q - 256'd1, 256'd3, 1'b1, 1'b1, "R9 sub with op flip");

    // R8: reset mid-run aborts
    op_a = PA; op_b = PB; op_sub = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(res_we === 1'b0 && done === 1'b0, "R8 reset aborts outputs", {res_we, done}, 0);
    @(negedge clk); rst_n = 1'b1;
    begin
      bit quiet;
      quiet = 1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (res_we !== 1'b0 || done !== 1'b0) quiet = 0;
      end
      chk(quiet, "R8 no activity after abort", quiet, 1);
    end
    run(256'd9, 256'd4, 1'b1, 1'b0, "R2 sub after abort");
    finish_up();
  end
endmodule